// File: doc/BRIEF.md
# Coprocessor Sleep/Wake Control Unit

This unit runs next to a small low-power coprocessor and carries out the coprocessor's sleep-related instructions. It decodes 32-bit instruction words offered on a valid/ready handshake. It recognises three operations. The first is a wake instruction that raises a request toward the always-on controller. The second is a period-select instruction that picks one of five programmable wake-up period registers. The third is a wait instruction that stalls instruction issue for a programmed number of cycles before the coprocessor may go to sleep. Every other instruction is accepted and has no effect.

A wake request is routed by the chip's power state. In deep sleep, when coprocessor wake-up is enabled, the unit pulses a chip wake request. When the chip is awake and the coprocessor interrupt is enabled, the unit sets a sticky interrupt flag instead, which software clears with a write-one-to-clear strobe. When the coprocessor reports that it has halted, the sleep timer loads the selected period and counts down to zero. It then pulses a restart output for one cycle and stops.

Top module: `slpwk_unit`

## Requirements
- R1: After reset, instrReady is 1 and waitBusy, wakeReq, intPending, timerRestart and timerActive are 0, and periodSel is 0.
- R2: An accepted word whose bits 31:28 equal 9 and bits 27:25 equal 0 is a wake instruction. When deepSleep and wakeEnable are both 1, it drives wakeReq high for exactly one cycle, starting the cycle after acceptance.
- R3: A wake instruction accepted while deepSleep is 0 and intEnable is 1 sets intPending on the following cycle. In every other combination of deepSleep, wakeEnable and intEnable, intPending is unchanged and wakeReq stays 0, apart from the case in R2.
- R4: intPending stays set until a cycle with intClear high clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: An accepted word with bits 31:28 equal to 9 and bits 27:25 equal to 1 takes its bits 2:0 as a period index. Values 0 to 4 appear on periodSel the cycle after acceptance.
- R6: A select index of 5, 6 or 7 is ignored, and periodSel keeps its previous value.
- R7: An accepted word with bits 31:28 equal to 4 is a wait instruction with count N in bits 15:0. waitBusy is high and instrReady is low for exactly N cycles starting the cycle after acceptance. With N equal to 0, instrReady never drops.
- R8: With cfgWrEn high, cfgWrData is written into period register cfgAddr for addresses 0 to 4. Addresses 5 to 7 write nothing.
- R9: A haltDone while the timer is idle loads period register periodSel, with value P. timerActive is then high, and timerRestart pulses for one cycle P+1 cycles after the loading edge, after which the timer is idle. A haltDone while the timer is active is ignored.
- R10: Words with any other opcode, and opcode 9 with bits 27:25 from 2 to 7, are accepted and change no output.
- R11: A word offered while instrReady is 0 is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | Instruction word offered |
| instrWord | input | 32 | Instruction word |
| instrReady | output | 1 | Unit can take an instruction |
| haltDone | input | 1 | Coprocessor has executed its halt |
| deepSleep | input | 1 | Chip is in deep sleep |
| wakeEnable | input | 1 | Coprocessor may wake the chip |
| intEnable | input | 1 | Coprocessor interrupt enabled |
| intClear | input | 1 | Write-one-to-clear for intPending |
| cfgWrEn | input | 1 | Period register write strobe |
| cfgAddr | input | 3 | Period register index |
| cfgWrData | input | 32 | Period register write data |
| wakeReq | output | 1 | One-cycle chip wake request |
| intPending | output | 1 | Sticky coprocessor interrupt |
| periodSel | output | 3 | Selected period register index |
| waitBusy | output | 1 | Wait countdown in progress |
| timerActive | output | 1 | Sleep timer counting |
| timerRestart | output | 1 | One-cycle timer expiry pulse |

## Verification
The checker covers the properties that hold on every cycle. A wake pulse may appear only when deep sleep and wake enable held in the cycle before. A rising interrupt flag needs the awake-and-enabled condition. The flag holds until it is cleared, the restart pulse lasts one cycle, periodSel stays in range, and periodSel cannot change while an offered word is stalled. Exact latencies can only be shown by the bench's sweeps over counts, indices and enable combinations: the length of a wait stall, the expiry time for each selected period, and the rejection of out-of-range selects and addresses and of unrelated opcodes.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned WAIT_W   = 16;
  localparam int unsigned SELFLD_W = 3;
  localparam logic [3:0] OP_SYSCTL = 4'd9;
  localparam logic [3:0] OP_WAIT   = 4'd4;
  localparam logic [2:0] SUB_WAKE  = 3'd0;
  localparam logic [2:0] SUB_SEL   = 3'd1;

  typedef struct packed {
    logic              waitLoad;
    logic [WAIT_W-1:0] waitValue;
    logic              timerStart;
  } dpStrobe_t;
endpackage

// File: rtl/slpwk_control.sv
module slpwk_control
  import slpwk_pkg::*;
#(
  parameter int unsigned NUM_PERIODS = 5,
  localparam int unsigned SEL_W = $clog2(NUM_PERIODS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               instrReady,
  input  logic               waitBusy,
  input  logic               haltDone,
  input  logic               deepSleep,
  input  logic               wakeEnable,
  input  logic               intEnable,
  input  logic               intClear,
  output dpStrobe_t          strobes,
  output logic [SEL_W-1:0]   periodSel,
  output logic               wakeReq,
  output logic               intPending
);
  logic                accept;
  logic [3:0]          opcode;
  logic [2:0]          subOp;
  logic [SELFLD_W-1:0] selField;
  logic                isWake, isSel, isWait;
  logic                selInRange;
  logic                setInt;

  assign instrReady = !waitBusy;
  assign accept     = instrValid && instrReady;
  assign opcode     = instrWord[INSTR_W-1 -: 4];
  assign subOp      = instrWord[INSTR_W-5 -: 3];
  assign selField   = instrWord[SELFLD_W-1:0];

  assign isWake = accept && (opcode == OP_SYSCTL) && (subOp == SUB_WAKE);
  assign isSel  = accept && (opcode == OP_SYSCTL) && (subOp == SUB_SEL);
  assign isWait = accept && (opcode == OP_WAIT);

  assign selInRange = (32'(selField) < NUM_PERIODS);
  assign setInt     = isWake && !deepSleep && intEnable;

  always_comb begin
    strobes            = '0;
    strobes.waitLoad   = isWait;
    strobes.waitValue  = instrWord[WAIT_W-1:0];
    strobes.timerStart = haltDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodSel  <= '0;
      wakeReq    <= 1'b0;
      intPending <= 1'b0;
    end else begin
      if (isSel && selInRange) periodSel <= SEL_W'(selField);
      wakeReq    <= isWake && deepSleep && wakeEnable;
      intPending <= setInt || (intPending && !intClear);
    end
  end
endmodule

// File: rtl/slpwk_datapath.sv
module slpwk_datapath
  import slpwk_pkg::*;
#(
  parameter int unsigned NUM_PERIODS = 5,
  parameter int unsigned PERIOD_W    = 32,
  localparam int unsigned SEL_W = $clog2(NUM_PERIODS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobes,
  input  logic [SEL_W-1:0]    periodSel,
  input  logic                cfgWrEn,
  input  logic [SEL_W-1:0]    cfgAddr,
  input  logic [PERIOD_W-1:0] cfgWrData,
  output logic                waitBusy,
  output logic                timerActive,
  output logic                timerRestart
);
  logic [PERIOD_W-1:0] periodReg [NUM_PERIODS];
  logic [PERIOD_W-1:0] selPeriod;
  logic [PERIOD_W-1:0] timerCnt;
  logic [WAIT_W-1:0]   waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PERIODS; i++) periodReg[i] <= '0;
    end else if (cfgWrEn) begin
      for (int i = 0; i < NUM_PERIODS; i++)
        if (cfgAddr == SEL_W'(i)) periodReg[i] <= cfgWrData;
    end
  end

  always_comb begin
    selPeriod = '0;
    for (int i = 0; i < NUM_PERIODS; i++)
      if (periodSel == SEL_W'(i)) selPeriod = periodReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.waitLoad) begin
      waitCnt <= strobes.waitValue;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
  assign waitBusy = (waitCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt     <= '0;
      timerActive  <= 1'b0;
      timerRestart <= 1'b0;
    end else begin
      timerRestart <= 1'b0;
      if (!timerActive) begin
        if (strobes.timerStart) begin
          timerCnt    <= selPeriod;
          timerActive <= 1'b1;
        end
      end else if (timerCnt == '0) begin
        timerActive  <= 1'b0;
        timerRestart <= 1'b1;
        timerCnt     <= selPeriod;
      end else begin
        timerCnt <= timerCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/slpwk_unit.sv
module slpwk_unit
  import slpwk_pkg::*;
#(
  parameter int unsigned NUM_PERIODS = 5,
  parameter int unsigned PERIOD_W    = 32,
  localparam int unsigned SEL_W = $clog2(NUM_PERIODS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instrWord,
  output logic                instrReady,
  input  logic                haltDone,
  input  logic                deepSleep,
  input  logic                wakeEnable,
  input  logic                intEnable,
  input  logic                intClear,
  input  logic                cfgWrEn,
  input  logic [SEL_W-1:0]    cfgAddr,
  input  logic [PERIOD_W-1:0] cfgWrData,
  output logic                wakeReq,
  output logic                intPending,
  output logic [SEL_W-1:0]    periodSel,
  output logic                waitBusy,
  output logic                timerActive,
  output logic                timerRestart
);
  dpStrobe_t strobes;

  slpwk_control #(.NUM_PERIODS(NUM_PERIODS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .instrValid(instrValid), .instrWord(instrWord), .instrReady(instrReady),
    .waitBusy(waitBusy), .haltDone(haltDone),
    .deepSleep(deepSleep), .wakeEnable(wakeEnable), .intEnable(intEnable),
    .intClear(intClear), .strobes(strobes), .periodSel(periodSel),
    .wakeReq(wakeReq), .intPending(intPending)
  );

  slpwk_datapath #(.NUM_PERIODS(NUM_PERIODS), .PERIOD_W(PERIOD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .periodSel(periodSel),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .waitBusy(waitBusy), .timerActive(timerActive), .timerRestart(timerRestart)
  );
endmodule

// File: rtl/slpwk_unit_checker.sv
module slpwk_unit_checker #(
  parameter int unsigned NUM_PERIODS = 5,
  localparam int unsigned SEL_W = $clog2(NUM_PERIODS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             instrValid,
  input logic             instrReady,
  input logic             deepSleep,
  input logic             wakeEnable,
  input logic             intEnable,
  input logic             intClear,
  input logic             wakeReq,
  input logic             intPending,
  input logic [SEL_W-1:0] periodSel,
  input logic             timerRestart
);
  // R2: a wake pulse needs deep sleep and wake enable in the issuing cycle
  p_wake_cond_r2: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(deepSleep && wakeEnable));

  // R3: the interrupt flag rises only when awake and enabled
  p_int_cond_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPending) |-> $past(!deepSleep && intEnable));

  // R4: the flag holds while no clear arrives
  p_int_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (intPending && !intClear) |=> intPending);

  // R6: the selection never leaves the valid range
  p_sel_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    32'(periodSel) < NUM_PERIODS);

  // R9: the restart output is a single-cycle pulse
  p_restart_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    timerRestart |=> !timerRestart);

  // R11: a stalled word cannot change the selection
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !instrReady) |=> $stable(periodSel));
endmodule

bind slpwk_unit slpwk_unit_checker #(.NUM_PERIODS(NUM_PERIODS)) chk_i (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrReady(instrReady),
  .deepSleep(deepSleep), .wakeEnable(wakeEnable), .intEnable(intEnable),
  .intClear(intClear), .wakeReq(wakeReq), .intPending(intPending),
  .periodSel(periodSel), .timerRestart(timerRestart)
);

// File: tb/slpwk_unit_tb_top.sv
`timescale 1ns/1ps
module slpwk_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        instrReady;
  logic        haltDone = 1'b0;
  logic        deepSleep = 1'b0;
  logic        wakeEnable = 1'b0;
  logic        intEnable = 1'b0;
  logic        intClear = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        wakeReq, intPending, waitBusy, timerActive, timerRestart;
  logic [2:0]  periodSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  slpwk_unit dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrReady(instrReady), .haltDone(haltDone), .deepSleep(deepSleep),
    .wakeEnable(wakeEnable), .intEnable(intEnable), .intClear(intClear),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .wakeReq(wakeReq), .intPending(intPending), .periodSel(periodSel),
    .waitBusy(waitBusy), .timerActive(timerActive), .timerRestart(timerRestart)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = w;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic cfgWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    intClear = 1'b1;
    @(negedge clk);
    intClear = 1'b0;
  endtask

  function automatic logic [31:0] selWord(int v);
    return {4'd9, 3'd1, 22'd0, 3'(v)};
  endfunction

  // timer run: expects restart P+1 negedges after the sample following the loading edge
  task automatic runTimer(string req, int p);
    int seen;
    @(negedge clk);
    haltDone = 1'b1;
    @(negedge clk);
    check({req, " active"}, int'(timerActive), 1);
    @(negedge clk);
    haltDone = 1'b0;
    seen = -1;
    if (timerRestart) seen = 1;
    for (int j = 2; j <= p + 4 && seen < 0; j++) begin
      @(negedge clk);
      if (timerRestart) seen = j;
    end
    check({req, " restart cycle"}, seen, p + 1);
    @(negedge clk);
    check({req, " idle after"}, int'(timerActive) + int'(timerRestart), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int expSel;
    int expInt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(instrReady), 1);
    check("R1 idle outputs", int'(waitBusy) + int'(wakeReq) + int'(intPending)
          + int'(timerRestart) + int'(timerActive), 0);
    check("R1 periodSel", int'(periodSel), 0);
    rstN = 1'b1;

    // R8 program periods 2+3*i, then try out-of-range addresses
    for (int i = 0; i < 5; i++) cfgWrite(3'(i), 32'(2 + 3 * i));
    for (int a = 5; a < 8; a++) cfgWrite(3'(a), 32'd40);

    // R9 default selection 0 uses period register 0
    runTimer("R9 sel0 default", 2);

    // R5/R6 select sweep with a timer run for each valid index (R8 R9)
    expSel = 0;
    for (int v = 0; v < 8; v++) begin
      issue(selWord(v));
      if (v < 5) expSel = v;
      check(v < 5 ? "R5 select" : "R6 select ignored", int'(periodSel), expSel);
      if (v < 5) runTimer("R8 R9 period", 2 + 3 * v);
    end
    issue(selWord(2));
    check("R5 reselect", int'(periodSel), 2);
    issue(selWord(7));
    check("R6 high value ignored", int'(periodSel), 2);
    runTimer("R6 R9 period kept", 8);

    // R7 wait sweep
    for (int n = 0; n < 7; n++) begin
      int busyCnt;
      int readyLow;
      issue({4'd4, 12'd0, 16'(n)});
      busyCnt = 0;
      readyLow = 0;
      for (int k = 0; k < n + 3; k++) begin
        if (waitBusy) busyCnt++;
        if (!instrReady) readyLow++;
        @(negedge clk);
      end
      check("R7 busy cycles", busyCnt, n);
      check("R7 ready low cycles", readyLow, n);
    end

    // R11 offer a select while stalled by a wait
    issue({4'd4, 12'd0, 16'd4});
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = selWord(4);
    @(negedge clk);
    instrValid = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 stalled word dropped", int'(periodSel), 2);

    // R2 R3 wake routing over all enable combinations
    for (int c = 0; c < 8; c++) begin
      bit ds, we, ie;
      ds = c[0]; we = c[1]; ie = c[2];
      pulseClear();
      deepSleep = ds; wakeEnable = we; intEnable = ie;
      issue({4'd9, 3'd0, 25'd0});
      check("R2 wakeReq", int'(wakeReq), int'(ds && we));
      expInt = int'(!ds && ie);
      check("R3 intPending", int'(intPending), expInt);
      @(negedge clk);
      check("R2 wake single pulse", int'(wakeReq), 0);
      if (expInt == 1) begin
        repeat (3) @(negedge clk);
        check("R4 sticky", int'(intPending), 1);
        pulseClear();
        check("R4 cleared", int'(intPending), 0);
      end
    end

    // R4 set and clear in the same cycle: set wins
    deepSleep = 1'b0; intEnable = 1'b1; wakeEnable = 1'b0;
    @(negedge clk);
    instrValid = 1'b1; instrWord = {4'd9, 3'd0, 25'd0}; intClear = 1'b1;
    @(negedge clk);
    instrValid = 1'b0; intClear = 1'b0;
    check("R4 set beats clear", int'(intPending), 1);
    pulseClear();

    // R10 unrelated opcodes and sub-operations change nothing
    deepSleep = 1'b1; wakeEnable = 1'b1;
    for (int op = 0; op < 16; op++) begin
      if (op != 4 && op != 9) begin
        issue({4'(op), 28'h000_0003});
        check("R10 other opcode", int'(periodSel) + 8 * int'(wakeReq)
              + 16 * int'(intPending) + 32 * int'(waitBusy), 2);
      end
    end
    for (int s = 2; s < 8; s++) begin
      issue({4'd9, 3'(s), 25'h3});
      check("R10 other sub-op", int'(periodSel) + 8 * int'(wakeReq)
            + 16 * int'(intPending) + 32 * int'(waitBusy), 2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule